// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds sixty-four 32-bit floating-point storage slots and the 32-bit status/control word that decides how logical register numbers reach them. Three bits of that word matter here: a bank-select bit that picks which half of the lower 32 slots is the current bank of sixteen registers, a pair-move bit that widens move accesses to 64 bits, and a precision bit that makes the generic single-or-double access operate on 64-bit register pairs. A 64-bit pair is two adjacent slots starting at an even physical index; the even slot holds the upper half.

One access is presented per cycle on a plain port: a kind code, an index and, for writes, 64 bits of data. Reads are combinational from the stored state. Writes commit on the rising clock edge, and a pair write updates both slots in that same edge. Every access is accepted in the cycle it is presented, so there is no ready signal and no back-pressure: the caller may issue one access every cycle. The block never converts between single and double formats. When the control bits would call for a conversion, it moves the raw low 32 bits unchanged and raises a conversion-needed flag, so the surrounding pipeline can do the conversion.

The control word is written either whole or one steering bit at a time. An access in the same cycle as a control write is mapped with the control value from before that edge.

Top module: `fpr_bank_file`

## Requirements
- R1: After reset every slot reads as zero and `ctl_q` is zero.
- R2: `ctl_wr_en` loads `ctl_wr_data` into the control word. `bit_wr_en` writes `bit_wr_val` into bit 21 (bank select, `bit_wr_sel`=0), bit 20 (pair move, sel=1) or bit 19 (precision, sel=2) and leaves every other bit unchanged. Sel=3 changes nothing.
- R3: Kind 0 (current single) with index i = `acc_idx[3:0]` reads and writes slot 16*bank+i. Read data sits in bits 31:0 with bits 63:32 zero, and writes take `acc_wdata[31:0]`.
- R4: Kind 1 (extended single) uses slot 16*(1-bank)+i, with the same data placement as R3.
- R5: Kind 6 (raw single) uses slot `acc_idx[5:0]` directly, so all 64 slots are reachable. Read bits 63:32 are zero.
- R6: Kind 2 (current double) uses the pair at base n = 16*bank+i with bit 0 cleared. Slot n supplies bits 63:32 and slot n+1 supplies bits 31:0. A write stores the two halves the same way in one edge.
- R7: Kind 3 (extended double) uses the pair at base 16*(1-bank)+i with bit 0 cleared, laid out as in R6.
- R8: Kind 4 (move) with the pair-move bit set uses the current double at i when i is even. When i is odd it uses the extended double at i with bit 0 cleared. `conv_flag` stays low.
- R9: Kind 4 with the pair-move bit clear acts as a current single access (R3) and raises `conv_flag`.
- R10: Kind 5 (single-or-double) with the precision bit set acts as the current double (R6) with `conv_flag` low. With the precision bit clear it acts as the current single (R3) with `conv_flag` high.
- R11: An access in the same cycle as a control write is mapped with the control value from before the edge. A whole-word write wins over a single-bit write in the same cycle.
- R12: No slot changes when `acc_en` or `acc_write` is low, or when the kind is 7. `rd_data` and `conv_flag` are zero when `acc_en` is low or the kind is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all state |
| ctl_wr_en | input | 1 | Load whole control word |
| ctl_wr_data | input | 32 | New control word |
| bit_wr_en | input | 1 | Write one steering bit |
| bit_wr_sel | input | 2 | 0 bank, 1 pair move, 2 precision, 3 none |
| bit_wr_val | input | 1 | Value for the selected bit |
| ctl_q | output | 32 | Current control word |
| acc_en | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_kind | input | 3 | Access kind code (see R3 to R12) |
| acc_idx | input | 6 | Logical index (bits 3:0) or raw slot (bits 5:0) |
| acc_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data for the present access |
| conv_flag | output | 1 | Format conversion would be needed |

## Verification
A wrong bank bit or a wrong mapping shows up in the next read of the affected index as data from another slot, in the same cycle as that read. A broken pair split appears as swapped or missing halves as soon as the pair or either raw slot is read back. Because the control word is visible on `ctl_q`, a corrupted steering bit is seen one cycle after the write that disturbed it. The reference model checks every cycle, so a fault appears at the first read that reaches the damaged state.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int FPR_SLOTS   = 64;
  localparam int FPR_WORD    = 32;
  localparam int FPR_BANK_SZ = 16;
  localparam int FPR_CTL_W   = 32;
  localparam int FPR_BANK_BIT = 21;
  localparam int FPR_SIZE_BIT = 20;
  localparam int FPR_PREC_BIT = 19;

  typedef enum logic [2:0] {
    K_CUR_S = 3'd0,
    K_EXT_S = 3'd1,
    K_CUR_D = 3'd2,
    K_EXT_D = 3'd3,
    K_MOVE  = 3'd4,
    K_FSD   = 3'd5,
    K_RAW_S = 3'd6,
    K_NONE  = 3'd7
  } acc_kind_e;

  typedef struct packed {
    logic bank;
    logic size;
    logic prec;
  } steer_t;
endpackage

// File: rtl/fpr_ctl_reg.sv
module fpr_ctl_reg #(
  parameter int CTL_W    = 32,
  parameter int BANK_BIT = 21,
  parameter int SIZE_BIT = 20,
  parameter int PREC_BIT = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             bit_wr_en,
  input  logic [1:0]       bit_wr_sel,
  input  logic             bit_wr_val,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] sel_mask;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    sel_mask = '0;
    unique case (bit_wr_sel)
      2'd0:    sel_mask[BANK_BIT] = 1'b1;
      2'd1:    sel_mask[SIZE_BIT] = 1'b1;
      2'd2:    sel_mask[PREC_BIT] = 1'b1;
      default: sel_mask = '0;
    endcase
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr_en)
      ctl_d = ctl_wr_data;
    else if (bit_wr_en)
      ctl_d = (ctl_q & ~sel_mask) | (bit_wr_val ? sel_mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // R1
  ctl_reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> ctl_q == '0);

  // R2
  bit_keep_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr_en && !ctl_wr_en) |=> (((ctl_q ^ $past(ctl_q)) & ~$past(sel_mask)) == '0));

  // R11
  full_word_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_q == $past(ctl_wr_data));
endmodule

// File: rtl/fpr_addr_map.sv
module fpr_addr_map
  import fpr_pkg::*;
#(
  parameter int BANK_SZ = 16,
  parameter int SLOTS   = 64,
  localparam int AW     = $clog2(SLOTS),
  localparam int LW     = $clog2(BANK_SZ)
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] idx,
  input  steer_t        steer,
  output logic          map_ok,
  output logic          map_pair,
  output logic          map_conv,
  output logic [AW-1:0] map_addr
);
  logic [AW-1:0] lidx;
  logic [AW-1:0] cur_base;
  logic [AW-1:0] ext_base;
  logic [AW-1:0] even_mask;
  acc_kind_e     k;

  assign lidx      = AW'(idx[LW-1:0]);
  assign cur_base  = AW'(BANK_SZ * int'(steer.bank)) + lidx;
  assign ext_base  = AW'(BANK_SZ * int'(!steer.bank)) + lidx;
  assign even_mask = ~AW'(1);
  assign k         = acc_kind_e'(kind);

  always_comb begin
    map_ok   = 1'b1;
    map_pair = 1'b0;
    map_conv = 1'b0;
    map_addr = cur_base;
    unique case (k)
      K_CUR_S: map_addr = cur_base;
      K_EXT_S: map_addr = ext_base;
      K_CUR_D: begin
        map_pair = 1'b1;
        map_addr = cur_base & even_mask;
      end
      K_EXT_D: begin
        map_pair = 1'b1;
        map_addr = ext_base & even_mask;
      end
      K_MOVE: begin
        if (steer.size) begin
          map_pair = 1'b1;
          map_addr = idx[0] ? (ext_base & even_mask) : (cur_base & even_mask);
        end else begin
          map_conv = 1'b1;
          map_addr = cur_base;
        end
      end
      K_FSD: begin
        if (steer.prec) begin
          map_pair = 1'b1;
          map_addr = cur_base & even_mask;
        end else begin
          map_conv = 1'b1;
          map_addr = cur_base;
        end
      end
      K_RAW_S: map_addr = idx;
      default: begin
        map_ok   = 1'b0;
        map_addr = '0;
      end
    endcase
  end
endmodule

// File: rtl/fpr_slot_store.sv
module fpr_slot_store #(
  parameter int SLOTS = 64,
  parameter int WORD  = 32,
  localparam int AW   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [AW-1:0]     wr_addr,
  input  logic [2*WORD-1:0] wr_data,
  input  logic              rd_pair,
  input  logic [AW-1:0]     rd_addr,
  output logic [2*WORD-1:0] rd_data
);
  logic [SLOTS-1:0][WORD-1:0] slot_q;
  logic [AW-1:0] wr_odd;
  logic [AW-1:0] rd_odd;

  assign wr_odd = wr_addr | AW'(1);
  assign rd_odd = rd_addr | AW'(1);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [AW-1:0] SELF = AW'(g);
    logic hit_hi;
    logic hit_lo;
    assign hit_hi = wr_en && (wr_addr == SELF);
    assign hit_lo = wr_en && wr_pair && (wr_odd == SELF) && (wr_addr != SELF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (hit_hi)
        slot_q[g] <= wr_pair ? wr_data[2*WORD-1:WORD] : wr_data[WORD-1:0];
      else if (hit_lo)
        slot_q[g] <= wr_data[WORD-1:0];
    end
  end

  always_comb begin
    if (rd_pair) rd_data = {slot_q[rd_addr], slot_q[rd_odd]};
    else         rd_data = {{WORD{1'b0}}, slot_q[rd_addr]};
  end

  // R6
  pair_base_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair) |-> !wr_addr[0]);

  // R6
  pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair) |=> (slot_q[$past(wr_addr)] == $past(wr_data[2*WORD-1:WORD]))
                        && (slot_q[$past(wr_odd)]  == $past(wr_data[WORD-1:0])));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot_q));
endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file
  import fpr_pkg::*;
#(
  parameter int SLOTS    = FPR_SLOTS,
  parameter int WORD     = FPR_WORD,
  parameter int BANK_SZ  = FPR_BANK_SZ,
  parameter int CTL_W    = FPR_CTL_W,
  parameter int BANK_BIT = FPR_BANK_BIT,
  parameter int SIZE_BIT = FPR_SIZE_BIT,
  parameter int PREC_BIT = FPR_PREC_BIT,
  localparam int AW      = $clog2(SLOTS),
  localparam int DW      = 2 * WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             bit_wr_en,
  input  logic [1:0]       bit_wr_sel,
  input  logic             bit_wr_val,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             acc_en,
  input  logic             acc_write,
  input  logic [2:0]       acc_kind,
  input  logic [AW-1:0]    acc_idx,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             conv_flag
);
  steer_t        steer;
  logic          map_ok;
  logic          map_pair;
  logic          map_conv;
  logic [AW-1:0] map_addr;
  logic          store_wr;
  logic [DW-1:0] store_rd;

  fpr_ctl_reg #(
    .CTL_W(CTL_W), .BANK_BIT(BANK_BIT), .SIZE_BIT(SIZE_BIT), .PREC_BIT(PREC_BIT)
  ) i_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .bit_wr_en(bit_wr_en), .bit_wr_sel(bit_wr_sel), .bit_wr_val(bit_wr_val),
    .ctl_q(ctl_q)
  );

  assign steer.bank = ctl_q[BANK_BIT];
  assign steer.size = ctl_q[SIZE_BIT];
  assign steer.prec = ctl_q[PREC_BIT];

  fpr_addr_map #(.BANK_SZ(BANK_SZ), .SLOTS(SLOTS)) i_map (
    .kind(acc_kind), .idx(acc_idx), .steer(steer),
    .map_ok(map_ok), .map_pair(map_pair), .map_conv(map_conv), .map_addr(map_addr)
  );

  assign store_wr = acc_en && acc_write && map_ok;

  fpr_slot_store #(.SLOTS(SLOTS), .WORD(WORD)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_wr), .wr_pair(map_pair), .wr_addr(map_addr), .wr_data(acc_wdata),
    .rd_pair(map_pair), .rd_addr(map_addr), .rd_data(store_rd)
  );

  assign rd_data   = (acc_en && map_ok) ? store_rd : '0;
  assign conv_flag = acc_en && map_ok && map_conv;

  // R9
  conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_flag |-> (rd_data[DW-1:WORD] == '0));

  // R5
  raw_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_kind == 3'd6) |-> (rd_data[DW-1:WORD] == '0 && !conv_flag));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (rd_data == '0 && !conv_flag));
endmodule

// File: tb/test_fpr_bank_file.sv
module test_fpr_bank_file;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        bit_wr_en = 1'b0;
  logic [1:0]  bit_wr_sel = '0;
  logic        bit_wr_val = 1'b0;
  logic [31:0] ctl_q;
  logic        acc_en = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_kind = '0;
  logic [5:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] rd_data;
  logic        conv_flag;

  fpr_bank_file i_fpr_bank_file (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .bit_wr_en(bit_wr_en), .bit_wr_sel(bit_wr_sel), .bit_wr_val(bit_wr_val),
    .ctl_q(ctl_q),
    .acc_en(acc_en), .acc_write(acc_write), .acc_kind(acc_kind), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .conv_flag(conv_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  logic [31:0] m [64];
  logic [31:0] c;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic void model_map(input int k, input int idx, output int a,
                                    output bit pair, output bit conv, output bit ok);
    int bank = int'(c[21]);
    int i4 = idx % 16;
    int cur = 16 * bank + i4;
    int ext = 16 * (1 - bank) + i4;
    pair = 0; conv = 0; ok = 1; a = cur;
    case (k)
      0: a = cur;
      1: a = ext;
      2: begin pair = 1; a = cur - (cur % 2); end
      3: begin pair = 1; a = ext - (ext % 2); end
      4: if (c[20]) begin
           pair = 1;
           a = (i4 % 2 == 1) ? ext - 1 : cur;
         end else conv = 1;
      5: if (c[19]) begin pair = 1; a = cur - (cur % 2); end
         else conv = 1;
      6: a = idx;
      default: begin ok = 0; a = 0; end
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R8/R9";
      5: return "R10";
      6: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic check64(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive, compare against the model, then advance the model at the edge.
  task automatic step(input string tag, input bit en, input bit wr, input int k, input int idx,
                      input logic [63:0] wd, input bit cw, input logic [31:0] cd,
                      input bit bw, input int bsel, input bit bval);
    int a; bit pair, conv, ok;
    logic [63:0] exp_rd;
    acc_en = en; acc_write = wr; acc_kind = 3'(k); acc_idx = 6'(idx); acc_wdata = wd;
    ctl_wr_en = cw; ctl_wr_data = cd; bit_wr_en = bw; bit_wr_sel = 2'(bsel); bit_wr_val = bval;
    #1;
    model_map(k, idx, a, pair, conv, ok);
    exp_rd = '0;
    if (en && ok) exp_rd = pair ? {m[a], m[a+1]} : {32'h0, m[a]};
    check64(tag, "rd_data", rd_data, exp_rd);
    check64(tag, "conv_flag", 64'(conv_flag), 64'(en && ok && conv));
    check64("R2", "ctl_q", 64'(ctl_q), 64'(c));
    @(posedge clk);
    if (en && wr && ok) begin
      if (pair) begin m[a] = wd[63:32]; m[a+1] = wd[31:0]; end
      else m[a] = wd[31:0];
    end
    if (cw) c = cd;
    else if (bw && bsel < 3) begin
      case (bsel)
        0: c[21] = bval;
        1: c[20] = bval;
        default: c[19] = bval;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic acc(input string tag, input bit wr, input int k, input int idx,
                     input logic [63:0] wd);
    step(tag, 1, wr, k, idx, wd, 0, 0, 0, 0, 0);
  endtask

  task automatic setbit(input int sel, input bit v);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 1, sel, v);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    c = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every slot and the control word start at zero
    for (int i = 0; i < 64; i++) acc("R1", 0, 6, i, 0);

    // R5: fill all slots through raw writes
    for (int i = 0; i < 64; i++) acc("R5", 1, 6, i, {32'hdead0000, 32'(32'h1000 + i * 3)});

    // R3 / R4 with bank 0 and bank 1
    acc("R3", 0, 0, 5, 0);
    acc("R4", 0, 1, 5, 0);
    setbit(0, 1);
    acc("R3", 0, 0, 5, 0);
    acc("R4", 0, 1, 5, 0);
    acc("R3", 1, 0, 15, 64'h0123_4567_89ab_cdef);
    acc("R5", 0, 6, 31, 0);

    // R6 / R7 pair reads and split writes, odd index clears bit 0
    acc("R6", 0, 2, 3, 0);
    acc("R7", 1, 3, 7, 64'haaaa_1111_bbbb_2222);
    acc("R5", 0, 6, 6, 0);
    acc("R5", 0, 6, 7, 0);
    acc("R6", 1, 2, 0, 64'hcccc_3333_dddd_4444);
    acc("R5", 0, 6, 16, 0);
    acc("R5", 0, 6, 17, 0);

    // R9 then R8: move with pair-move clear and set, even and odd index
    acc("R9", 0, 4, 2, 0);
    acc("R9", 1, 4, 9, 64'hffff_ffff_5555_6666);
    setbit(1, 1);
    acc("R8", 0, 4, 4, 0);
    acc("R8", 0, 4, 5, 0);
    acc("R8", 1, 4, 11, 64'h7777_8888_9999_aaaa);
    acc("R5", 0, 6, 10, 0);
    acc("R5", 0, 6, 11, 0);

    // R10: single-or-double with precision clear and set
    acc("R10", 0, 5, 6, 0);
    setbit(2, 1);
    acc("R10", 0, 5, 6, 0);
    acc("R10", 1, 5, 13, 64'h1212_3434_5656_7878);

    // R2: bit select 3 changes nothing, whole-word load
    setbit(3, 1);
    step("R2", 0, 0, 0, 0, 0, 1, 32'h0028_0000, 0, 0, 0);

    // R11: access in the same cycle as a control write uses the old control
    step("R11", 1, 1, 0, 2, 64'h0000_0000_abab_abab, 1, 32'h0000_0000, 0, 0, 0);
    acc("R11", 0, 0, 2, 0);
    step("R11", 0, 0, 0, 0, 0, 1, 32'hffff_ffff, 1, 0, 0);
    acc("R11", 0, 0, 2, 0);

    // R12: disabled writes and the unused kind leave every slot alone
    step("R12", 0, 1, 6, 1, 64'h1, 0, 0, 0, 0, 0);
    acc("R12", 1, 7, 1, 64'h2);
    acc("R12", 0, 6, 1, 0);
    acc("R12", 0, 7, 3, 0);

    // Mixed traffic across all kinds and control settings
    for (int n = 0; n < 3000; n++) begin
      int k = int'($urandom % 8);
      bit cw = ($urandom % 16) == 0;
      bit bw = ($urandom % 8) == 0;
      step(tag_of(k), ($urandom % 8) != 0, $urandom % 2, k, int'($urandom % 64),
           {$urandom, $urandom}, cw, $urandom, bw, int'($urandom % 4), $urandom % 2);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule